// File: doc/BRIEF.md
# Converter Host Bus Interface

This block sits between a host bus and the conversion sequencer of a successive-approximation converter. It decodes a chip enable, an active-low select, a read/convert select, a byte address and a format select. From these it produces either a read of the latest result onto a 12-bit output bus or a single-cycle convert-start pulse. The pulse goes to the sequencer together with the address value captured at that moment, which the sequencer uses to choose a short or a full conversion.

The output bus is split into 4-bit lanes, each with its own enable, so that three-state buffers can be modelled. In wide format all 12 result bits are driven together. In narrow format the two upper lanes form one left-justified byte. Address low selects the 8 most significant bits. Address high selects the 4 least significant bits followed by four zeros. A stand-alone strap ignores enable, select, address and format: the read/convert pin alone enables reads while high and starts a conversion on its falling edge. All inputs share one clock, and every output is registered.

Top module: `adc_host_if`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `lane_oe`, `dout`, `cnv_start` and `cnv_short` are all zero.
- R2: With `standalone`=0, when `chip_en`=0 or `sel_n`=1, no lane is enabled on the next cycle and no start pulse is produced. A lane that is not enabled always carries zeros on `dout`.
- R3: A read occurs when the decode is active, `rd_cnv`=1 and `conv_busy`=0. With `wide_fmt`=1, the next cycle has `lane_oe`=3'b111 and `dout` equal to `result`.
- R4: In a narrow read (`wide_fmt`=0) with `byte_addr`=0, the next cycle has `lane_oe`=3'b110, `dout[11:4]`=`result[11:4]` and `dout[3:0]`=0.
- R5: In a narrow read with `byte_addr`=1, the next cycle has `lane_oe`=3'b110, `dout[11:8]`=`result[3:0]` and `dout[7:0]`=0.
- R6: A start occurs when the convert condition (decode active and `rd_cnv`=0) goes from false to true. `cnv_start` is then high for exactly one cycle, on the cycle after the change.
- R7: `cnv_short` takes the effective address value when `cnv_start` rises and holds it otherwise.
- R8: While `conv_busy`=1, no lane is enabled on the next cycle.
- R9: A convert condition that rises while `conv_busy`=1 produces no start, either then or later while the condition is held.
- R10: With `standalone`=1, `rd_cnv`=1 gives a wide read whatever the values of `chip_en`, `sel_n`, `byte_addr` and `wide_fmt`. A falling `rd_cnv` starts a full conversion (`cnv_short`=0).
- R11: In stand-alone mode with a low trigger pulse, the lanes are disabled from the falling edge of `rd_cnv`. They are enabled again only after `conv_busy` drops.
- R12: If `rd_cnv` is already high when enable and select become active, a read takes place for as long as they stay active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| sel_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | 1 = read, 0 = convert |
| byte_addr | input | 1 | Byte address / short-conversion select |
| wide_fmt | input | 1 | 1 = 12-bit word, 0 = left-justified bytes |
| standalone | input | 1 | Stand-alone strap |
| conv_busy | input | 1 | Conversion in progress, from sequencer |
| result | input | 12 | Latest conversion result |
| cnv_start | output | 1 | One-cycle convert-start pulse |
| cnv_short | output | 1 | Address captured with the last start |
| dout | output | 12 | Steered data bus, zero on disabled lanes |
| lane_oe | output | 3 | Per-lane output enable, bit 2 = bits 11:8 |

## Verification
The assertions assume that every input is synchronous and stable between clock edges. They also assume that `conv_busy` comes from a sequencer that only rises after a start. Because the checks compare each output with the inputs of the previous cycle, they also require `standalone` to stay fixed during an access. The stimulus changes inputs only at the falling clock edge and models `conv_busy` by hand, raising it only after a start. It toggles `standalone` only at cycles where the expected outputs do not depend on the old mode.

// File: rtl/adc_host_pkg.sv
// Shared sizes for the converter host bus interface.
// Assumes the result splits into equal lanes and a byte is two lanes.
package adc_host_pkg;
    localparam int unsigned DATA_W = 12;
    localparam int unsigned LANE_W = 4;
    localparam int unsigned NLANE  = DATA_W / LANE_W;
    localparam int unsigned BYTE_W = 2 * LANE_W;

    typedef struct packed {
        logic act;    // decode active
        logic rd;     // read decoded and sequencer idle
        logic cv;     // convert condition
        logic addr;   // effective byte address
        logic wide;   // effective wide format
    } dec_t;
endpackage

// File: rtl/adc_ctl_decode.sv
// Combinational decode of the host control pins.
// Assumes all pins are synchronous to clk. The stand-alone strap forces
// active decode, address 0 and wide format.
module adc_ctl_decode
    import adc_host_pkg::*;
(
    input  logic chip_en,
    input  logic sel_n,
    input  logic rd_cnv,
    input  logic byte_addr,
    input  logic wide_fmt,
    input  logic standalone,
    input  logic conv_busy,
    output dec_t dec
);
    // Form the decoded request from the pins and the strap.
    always_comb begin
        dec.act  = standalone | (chip_en & ~sel_n);
        dec.addr = standalone ? 1'b0 : byte_addr;
        dec.wide = standalone | wide_fmt;
        dec.rd   = dec.act & rd_cnv & ~conv_busy;
        dec.cv   = dec.act & ~rd_cnv;
    end
endmodule

// File: rtl/adc_cnv_edge.sv
// Registered rising-edge detector on the convert condition.
// Produces a one-cycle start and captures the address with it.
// A start is dropped if the sequencer is busy at the edge.
module adc_cnv_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cv,
    input  logic addr,
    input  logic conv_busy,
    output logic cnv_start,
    output logic cnv_short
);
    logic cv_q;

    // Remember the previous convert condition, whether or not busy.
    always_ff @(posedge clk) begin
        if (!rst_n) cv_q <= 1'b0;
        else        cv_q <= cv;
    end

    // Issue the pulse and capture the address on a new convert request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_start <= 1'b0;
            cnv_short <= 1'b0;
        end else begin
            cnv_start <= cv & ~cv_q & ~conv_busy;
            if (cv & ~cv_q & ~conv_busy) cnv_short <= addr;
        end
    end
endmodule

// File: rtl/adc_byte_steer.sv
// Registered data steering and per-lane output enables.
// Wide format drives all lanes. Narrow format drives the upper byte
// with either the high bits or the low bits followed by zeros.
// A disabled lane always carries zeros.
module adc_byte_steer
    import adc_host_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          wide,
    input  logic          addr,
    input  logic [DW-1:0] result,
    output logic [DW-1:0] dout,
    output logic [DW/LW-1:0] lane_oe
);
    localparam int unsigned NL    = DW / LW;
    localparam int unsigned BW    = 2 * LW;
    localparam int unsigned BLANE = BW / LW;
    localparam int unsigned REM_W = DW - BW;
    localparam int unsigned PAD_W = BW - REM_W;

    logic [BW-1:0] hi_byte, lo_byte;
    logic [DW-1:0] word;

    // Build the candidate word for the selected format.
    always_comb begin
        hi_byte = result[DW-1:REM_W];
        lo_byte = BW'(result[REM_W-1:0]) << PAD_W;
        if (wide)      word = result;
        else if (addr) word = {lo_byte, {REM_W{1'b0}}};
        else           word = {hi_byte, {REM_W{1'b0}}};
    end

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic on;
        // A lane is used in wide format or when it is in the upper byte.
        assign on = rd & (wide | (i >= NL - BLANE));

        // Register the lane enable and its gated data.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_oe[i]             <= 1'b0;
                dout[i*LW +: LW]       <= '0;
            end else begin
                lane_oe[i]             <= on;
                dout[i*LW +: LW]       <= on ? word[i*LW +: LW] : '0;
            end
        end
    end
endmodule

// File: rtl/adc_host_if.sv
// Host bus interface for a successive-approximation converter.
// Decodes the host pins, issues convert starts to the sequencer, and
// steers the result onto lane-enabled outputs. Outputs are registered.
// Assumes synchronous inputs and a sequencer busy flag.
module adc_host_if
    import adc_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              sel_n,
    input  logic              rd_cnv,
    input  logic              byte_addr,
    input  logic              wide_fmt,
    input  logic              standalone,
    input  logic              conv_busy,
    input  logic [DATA_W-1:0] result,
    output logic              cnv_start,
    output logic              cnv_short,
    output logic [DATA_W-1:0] dout,
    output logic [NLANE-1:0]  lane_oe
);
    dec_t dec;

    adc_ctl_decode u_dec (
        .chip_en    (chip_en),
        .sel_n      (sel_n),
        .rd_cnv     (rd_cnv),
        .byte_addr  (byte_addr),
        .wide_fmt   (wide_fmt),
        .standalone (standalone),
        .conv_busy  (conv_busy),
        .dec        (dec)
    );

    adc_cnv_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cv        (dec.cv),
        .addr      (dec.addr),
        .conv_busy (conv_busy),
        .cnv_start (cnv_start),
        .cnv_short (cnv_short)
    );

    adc_byte_steer #(.DW(DATA_W), .LW(LANE_W)) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (dec.rd),
        .wide    (dec.wide),
        .addr    (dec.addr),
        .result  (result),
        .dout    (dout),
        .lane_oe (lane_oe)
    );
endmodule

// File: rtl/adc_host_if_chk.sv
// Protocol checker for adc_host_if, attached by bind.
// Assumes standalone is static across each checked cycle pair.
module adc_host_if_chk
    import adc_host_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              sel_n,
    input logic              wide_fmt,
    input logic              standalone,
    input logic              conv_busy,
    input logic              cnv_start,
    input logic              cnv_short,
    input logic [DATA_W-1:0] dout,
    input logic [NLANE-1:0]  lane_oe
);
    AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> (lane_oe == '0 && !cnv_start)); // R1
    AST_IDLE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (!standalone && (!chip_en || sel_n)) |=> (lane_oe == '0 && !cnv_start)); // R2
    AST_OFF_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_oe == '0) |-> (dout == '0)); // R2
    AST_NARROW_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!standalone && !wide_fmt) |=> (!lane_oe[0] && dout[LANE_W-1:0] == '0)); // R4
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start); // R6
    AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_start |-> $stable(cnv_short)); // R7
    AST_BUSY_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> (lane_oe == '0)); // R8
    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> !cnv_start); // R9
endmodule

bind adc_host_if adc_host_if_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .sel_n      (sel_n),
    .wide_fmt   (wide_fmt),
    .standalone (standalone),
    .conv_busy  (conv_busy),
    .cnv_start  (cnv_start),
    .cnv_short  (cnv_short),
    .dout       (dout),
    .lane_oe    (lane_oe)
);

// File: tb/sim_adc_host_if.sv
// Scoreboard bench: the driver pushes expected outputs, the monitor
// compares them one cycle later at the falling edge.
module sim_adc_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b0, sel_n = 1'b1, rd_cnv = 1'b0;
    logic        byte_addr = 1'b0, wide_fmt = 1'b1, standalone = 1'b0;
    logic        conv_busy = 1'b0;
    logic [11:0] result = 12'h000;
    logic        cnv_start, cnv_short;
    logic [11:0] dout;
    logic [2:0]  lane_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        int          due;
        logic [2:0]  oe;
        logic [11:0] d;
        logic        st;
        logic        sh;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    adc_host_if u0 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sel_n(sel_n),
        .rd_cnv(rd_cnv), .byte_addr(byte_addr), .wide_fmt(wide_fmt),
        .standalone(standalone), .conv_busy(conv_busy), .result(result),
        .cnv_start(cnv_start), .cnv_short(cnv_short), .dout(dout),
        .lane_oe(lane_oe)
    );

    // Monitor: pop items that fall due and compare with the outputs.
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (lane_oe !== e.oe || dout !== e.d || cnv_start !== e.st || cnv_short !== e.sh) begin
                errors++;
                $display("FAIL %s: oe=%b dout=%h start=%b short=%b expected oe=%b dout=%h start=%b short=%b",
                         e.tag, lane_oe, dout, cnv_start, cnv_short, e.oe, e.d, e.st, e.sh);
            end
        end
    end

    // Driver: apply pins at the falling edge and queue the next-cycle result.
    task automatic step(input logic ce, csn, rc, a0, fmt, sa, busy,
                        input logic [11:0] res,
                        input logic [2:0] eoe, input logic [11:0] ed,
                        input logic est, esh, input string tag);
        exp_t e;
        @(negedge clk);
        chip_en = ce; sel_n = csn; rd_cnv = rc; byte_addr = a0;
        wide_fmt = fmt; standalone = sa; conv_busy = busy; result = res;
        e.due = cyc + 1; e.oe = eoe; e.d = ed; e.st = est; e.sh = esh; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: expired, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R1 reset state
        if (lane_oe !== 3'b000 || dout !== 12'h000 || cnv_start !== 1'b0 || cnv_short !== 1'b0) begin
            errors++;
            $display("FAIL R1: oe=%b dout=%h start=%b short=%b expected all zero",
                     lane_oe, dout, cnv_start, cnv_short);
        end
        @(negedge clk); rst_n = 1'b1;
        //    ce csn rc a0 fmt sa busy res      oe      dout     st sh
        step(0, 1, 1, 0, 1, 0, 0, 12'hABC, 3'b000, 12'h000, 0, 0, "R1_R2 idle");
        step(1, 0, 1, 0, 1, 0, 0, 12'hABC, 3'b111, 12'hABC, 0, 0, "R3_R12 wide read");
        step(1, 0, 1, 0, 0, 0, 0, 12'hABC, 3'b110, 12'hAB0, 0, 0, "R4 narrow even");
        step(1, 0, 1, 1, 0, 0, 0, 12'hABC, 3'b110, 12'hC00, 0, 0, "R5 narrow odd");
        step(1, 1, 1, 1, 0, 0, 0, 12'hABC, 3'b000, 12'h000, 0, 0, "R2 deselect");
        step(1, 1, 0, 1, 0, 0, 0, 12'hABC, 3'b000, 12'h000, 0, 0, "R2 convert while deselected");
        step(1, 0, 0, 1, 0, 0, 0, 12'hABC, 3'b000, 12'h000, 1, 1, "R6_R7 start short");
        step(1, 0, 0, 0, 0, 0, 0, 12'hABC, 3'b000, 12'h000, 0, 1, "R6_R7 single pulse hold");
        step(1, 0, 1, 0, 1, 0, 1, 12'hABC, 3'b000, 12'h000, 0, 1, "R8 read while busy");
        step(1, 0, 0, 0, 1, 0, 1, 12'hABC, 3'b000, 12'h000, 0, 1, "R9 convert while busy");
        step(1, 0, 0, 0, 1, 0, 0, 12'hABC, 3'b000, 12'h000, 0, 1, "R9 held after busy");
        step(1, 0, 1, 0, 1, 0, 0, 12'h5A3, 3'b111, 12'h5A3, 0, 1, "R3 read after busy");
        step(0, 1, 1, 0, 1, 0, 0, 12'h5A3, 3'b000, 12'h000, 0, 1, "R2 disable");
        step(1, 0, 1, 0, 1, 0, 0, 12'h5A3, 3'b111, 12'h5A3, 0, 1, "R12 enable with rc high");
        step(0, 1, 1, 0, 1, 0, 0, 12'h5A3, 3'b000, 12'h000, 0, 1, "R12 brief read ends");
        // Stand-alone: other pins deliberately set to inactive or narrow values.
        step(0, 1, 1, 1, 0, 1, 0, 12'h123, 3'b111, 12'h123, 0, 1, "R10 standalone read");
        step(0, 1, 0, 1, 0, 1, 0, 12'h123, 3'b000, 12'h000, 1, 0, "R10_R11 standalone start");
        step(0, 1, 0, 1, 0, 1, 1, 12'h123, 3'b000, 12'h000, 0, 0, "R11 low during busy");
        step(0, 1, 1, 1, 0, 1, 1, 12'h123, 3'b000, 12'h000, 0, 0, "R11 high during busy");
        step(0, 1, 1, 1, 0, 1, 0, 12'h456, 3'b111, 12'h456, 0, 0, "R11 valid after done");
        step(0, 1, 0, 1, 0, 1, 0, 12'h456, 3'b000, 12'h000, 1, 0, "R10 second start");
        step(0, 1, 1, 1, 0, 1, 0, 12'h456, 3'b111, 12'h456, 0, 0, "R10 high pulse read");
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule